// File: doc/BRIEF.md
# Overflow-Triggered Branch Sample Recorder

The recorder captures the source and target addresses of retired control-flow changes into a fixed buffer of slots. It makes one pass over the buffer and then stops. Software can start capture directly by setting an enable flag. Capture also starts on its own when a selected companion event counter reports an overflow pulse. Every branch strobe seen while enabled is recorded, with no filtering of any kind. When the final slot has been written, the block clears its own enable flag, keeps all slot contents, and raises an interrupt request.

Software reaches the block through a flat register port. Each slot is a pair of registers: a source address register and a target address register. One configuration register holds the enable flag, a flag showing that branches were recorded, the next-write slot index and the counter-select field. Software may plant a marker value in any target register. A later reader can then spot where the fresh entries end.

Top module: `brtrace_rec`

## Requirements
- R1: Register address 2k reads the source address of slot k and 2k+1 reads its target address, for k in 0..DEPTH-1. Address 2*DEPTH (32 by default) is the configuration register. Any other address reads zero and ignores writes. Stored addresses are zero-extended to 64 bits on read.
- R2: The configuration register reads enable at bit 2, the valid flag at bit 5, the next-write index at bits 19:16 and the counter-select field at bits 26:24. Bits 4:3 always read 11b, and every other bit reads 0.
- R3: While enable is 1, each cycle with `br_valid` high stores `br_from` and `br_to` in the slot named by the next-write index, and the index then advances by one.
- R4: Recording into slot DEPTH-1 has three effects: the index wraps to 0, enable clears, and later strobes leave every slot unchanged until enable is set again.
- R5: `irq` rises at the same clock edge as the recording into the last slot. It then stays high until a configuration write with bit 2 and bit 5 both 0; any other write leaves it set.
- R6: A pulse on `ovf_vec[sel]` sets enable, where sel is the counter-select field, provided enable is 0 and `irq` is 0. Pulses on other counters are ignored, and so are pulses while `irq` is high.
- R7: The valid flag becomes 1 at the edge that records a branch. Otherwise it changes only through a configuration write.
- R8: A configuration write loads enable, valid, index and select from the written data. A branch strobe in the same cycle is dropped, and an overflow pulse in the same cycle is ignored.
- R9: A write to a target register stores the low AW bits of the data, while writes to source registers are ignored. If a branch is recorded into the same slot in the same cycle, the recorded branch wins.
- R10: After reset every slot reads 0, the configuration register reads 0x18, and `irq` and `rec_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Retired branch strobe |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| ovf_vec | input | NCTR | Overflow pulses, one per event counter |
| reg_addr | input | 6 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Saturation interrupt request |
| rec_active | output | 1 | Current value of the enable flag |

## Verification
On every cycle the bound checker checks several things:
- Filling the last slot raises `irq` and drops recording.
- `irq` persists across cycles that have no configuration write.
- Each recorded branch sets the valid flag and advances the index by exactly one.
- The fixed bits always read 11b.

Only the bench's scenarios can show the remaining behaviours: which counter actually arms capture, that overflow pulses are ignored while the interrupt is pending, write-versus-record priority on a slot, and that slot contents are unchanged after saturation. The bench does this by comparing the full read-back against its behavioural model.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  localparam int REG_W  = 64;
  localparam int REG_AW = 6;
  localparam int EN_BIT = 2;
  localparam int FIX_LO = 3;
  localparam int VB_BIT = 5;
  localparam int IDX_LO = 16;
  localparam int SEL_LO = 24;

  // slot index after one recording, wrapping at depth
  function automatic int unsigned slot_after(int unsigned cur, int unsigned depth);
    return (cur + 1 == depth) ? 0 : cur + 1;
  endfunction

  // true when the write data clears both enable and valid
  function automatic logic is_irq_clear(logic [REG_W-1:0] wd);
    return !wd[EN_BIT] && !wd[VB_BIT];
  endfunction
endpackage

// File: rtl/brtrace_ctl.sv
module brtrace_ctl
  import brtrace_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCTR  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SEL_W = $clog2(NCTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             br_valid,
  input  logic [NCTR-1:0]  ovf_vec,
  output logic             en_q,
  output logic             vb_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             irq_q,
  output logic             rec_fire,
  output logic             sat_evt,
  output logic             arm_evt
);
  logic ovf_sel;

  always_comb begin
    ovf_sel  = ovf_vec[sel_q];
    rec_fire = en_q && br_valid && !cfg_wr;
    sat_evt  = rec_fire && (idx_q == IDX_W'(DEPTH - 1));
    arm_evt  = !cfg_wr && !en_q && !irq_q && ovf_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      vb_q  <= 1'b0;
      idx_q <= '0;
      sel_q <= '0;
      irq_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q  <= cfg_wdata[EN_BIT];
      vb_q  <= cfg_wdata[VB_BIT];
      idx_q <= cfg_wdata[IDX_LO +: IDX_W];
      sel_q <= cfg_wdata[SEL_LO +: SEL_W];
      if (is_irq_clear(cfg_wdata)) irq_q <= 1'b0;
    end else if (rec_fire) begin
      vb_q  <= 1'b1;
      idx_q <= IDX_W'(slot_after(int'(idx_q), DEPTH));
      if (sat_evt) begin
        en_q  <= 1'b0;
        irq_q <= 1'b1;
      end
    end else if (arm_evt) begin
      en_q <= 1'b1;
    end
  end
endmodule

// File: rtl/brtrace_slots.sv
module brtrace_slots #(
  parameter int DEPTH = 16,
  parameter int AW    = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_fire,
  input  logic [IDX_W-1:0] rec_slot,
  input  logic [AW-1:0]    br_from,
  input  logic [AW-1:0]    br_to,
  input  logic             sw_to_we,
  input  logic [IDX_W-1:0] sw_slot,
  input  logic [AW-1:0]    sw_data,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [AW-1:0]    rd_from,
  output logic [AW-1:0]    rd_to
);
  logic [AW-1:0] from_q [DEPTH];
  logic [AW-1:0] to_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_rec, hit_sw;
    assign hit_rec = rec_fire && (rec_slot == IDX_W'(g));
    assign hit_sw  = sw_to_we && (sw_slot == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        from_q[g] <= '0;
        to_q[g]   <= '0;
      end else if (hit_rec) begin
        from_q[g] <= br_from;
        to_q[g]   <= br_to;
      end else if (hit_sw) begin
        to_q[g] <= sw_data;
      end
    end
  end

  assign rd_from = from_q[rd_slot];
  assign rd_to   = to_q[rd_slot];
endmodule

// File: rtl/brtrace_rec.sv
module brtrace_rec
  import brtrace_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 48,
  parameter int NCTR  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [AW-1:0]     br_from,
  input  logic [AW-1:0]     br_to,
  input  logic [NCTR-1:0]   ovf_vec,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              rec_active
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SEL_W = $clog2(NCTR);
  localparam logic [REG_AW-1:0] CFG_ADDR = REG_AW'(2 * DEPTH);

  logic             in_buf, cfg_wr, sw_to_we;
  logic [IDX_W-1:0] acc_slot;
  logic             en_q, vb_q, irq_q, rec_fire, sat_evt, arm_evt;
  logic [IDX_W-1:0] rec_slot;
  logic [SEL_W-1:0] sel_q;
  logic [AW-1:0]    rd_from, rd_to;

  assign in_buf   = reg_addr < CFG_ADDR;
  assign acc_slot = reg_addr[IDX_W:1];
  assign cfg_wr   = reg_we && (reg_addr == CFG_ADDR);
  assign sw_to_we = reg_we && in_buf && reg_addr[0];

  brtrace_ctl #(.DEPTH(DEPTH), .NCTR(NCTR)) ctl_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(reg_wdata),
    .br_valid(br_valid), .ovf_vec(ovf_vec),
    .en_q(en_q), .vb_q(vb_q), .idx_q(rec_slot), .sel_q(sel_q), .irq_q(irq_q),
    .rec_fire(rec_fire), .sat_evt(sat_evt), .arm_evt(arm_evt)
  );

  brtrace_slots #(.DEPTH(DEPTH), .AW(AW)) slots_i (
    .clk(clk), .rst_n(rst_n), .rec_fire(rec_fire), .rec_slot(rec_slot),
    .br_from(br_from), .br_to(br_to),
    .sw_to_we(sw_to_we), .sw_slot(acc_slot), .sw_data(reg_wdata[AW-1:0]),
    .rd_slot(acc_slot), .rd_from(rd_from), .rd_to(rd_to)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_buf) begin
      reg_rdata[AW-1:0] = reg_addr[0] ? rd_to : rd_from;
    end else if (reg_addr == CFG_ADDR) begin
      reg_rdata[EN_BIT]              = en_q;
      reg_rdata[FIX_LO +: 2]         = 2'b11;
      reg_rdata[VB_BIT]              = vb_q;
      reg_rdata[IDX_LO +: IDX_W]     = rec_slot;
      reg_rdata[SEL_LO +: SEL_W]     = sel_q;
    end
  end

  assign irq        = irq_q;
  assign rec_active = en_q;
endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rec_active,
  input logic [5:0]       reg_addr,
  input logic [63:0]      reg_rdata,
  input logic             cfg_wr,
  input logic             rec_fire,
  input logic [IDX_W-1:0] rec_slot,
  input logic             vb_q
);
  // R5
  sat_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_fire && rec_slot == IDX_W'(DEPTH - 1)) |=> (irq && !rec_active));
  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_wr) |=> irq);
  // R4
  irq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !rec_active);
  // R7
  vb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_fire |=> vb_q);
  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_fire && rec_slot != IDX_W'(DEPTH - 1)) |=> (rec_slot == $past(rec_slot) + 1'b1));
  // R2
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 6'(2 * DEPTH)) |-> (reg_rdata[4:3] == 2'b11));
endmodule

bind brtrace_rec brtrace_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rec_active(rec_active),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .cfg_wr(cfg_wr),
  .rec_fire(rec_fire), .rec_slot(rec_slot), .vb_q(vb_q)
);

// File: tb/brtrace_rec_tb.sv
module brtrace_rec_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        br_valid = 0;
  logic [47:0] br_from = 0, br_to = 0;
  logic [7:0]  ovf_vec = 0;
  logic [5:0]  reg_addr = 0;
  logic        reg_we = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic        irq, rec_active;

  always #5 clk = ~clk;

  brtrace_rec dut_i (.*);

  // reference model
  logic [47:0] m_from [16];
  logic [47:0] m_to   [16];
  int m_idx, m_sel;
  bit m_en, m_vb, m_irq;
  int nchk = 0, nfail = 0;
  string cur_req = "R10";
  bit done = 0;

  function automatic logic [63:0] exp_rd(int a);
    logic [63:0] v = '0;
    if (a < 32) v[47:0] = a[0] ? m_to[a/2] : m_from[a/2];
    else if (a == 32) begin
      v[2] = m_en; v[4:3] = 2'b11; v[5] = m_vb;
      v[19:16] = 4'(m_idx); v[26:24] = 3'(m_sel);
    end
    return v;
  endfunction

  task automatic model_step();
    bit cw, fire;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_from[i] = 0; m_to[i] = 0; end
      m_idx = 0; m_sel = 0; m_en = 0; m_vb = 0; m_irq = 0;
      return;
    end
    cw = reg_we && reg_addr == 32;
    fire = m_en && br_valid && !cw;
    if (reg_we && reg_addr < 32 && reg_addr[0]) m_to[reg_addr/2] = reg_wdata[47:0];
    if (cw) begin
      m_en = reg_wdata[2]; m_vb = reg_wdata[5];
      m_idx = int'(reg_wdata[19:16]); m_sel = int'(reg_wdata[26:24]);
      if (!reg_wdata[2] && !reg_wdata[5]) m_irq = 0;
    end else if (fire) begin
      m_from[m_idx] = br_from; m_to[m_idx] = br_to; m_vb = 1;
      if (m_idx == 15) begin m_idx = 0; m_en = 0; m_irq = 1; end
      else m_idx++;
    end else if (!m_en && !m_irq && ovf_vec[m_sel]) m_en = 1;
  endtask

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("reg_rdata", reg_rdata, exp_rd(int'(reg_addr)));
    check("irq", 64'(irq), 64'(m_irq));
    check("rec_active", 64'(rec_active), 64'(m_en));
  endtask

  task automatic wr(int a, logic [63:0] d);
    reg_addr = 6'(a); reg_we = 1; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic branch(int n);
    for (int i = 0; i < n; i++) begin
      br_valid = 1;
      br_from = 48'h4000_0000 + 48'(i * 16 + 3);
      br_to   = 48'h8000_1000 + 48'($urandom_range(0, 65535));
      tick();
    end
    br_valid = 0;
  endtask

  task automatic sweep(int lo, int hi);
    for (int a = lo; a <= hi; a++) begin reg_addr = 6'(a); tick(); end
  endtask

  initial begin
    model_step();
    reg_addr = 32;
    cur_req = "R10"; tick(); tick();
    check("cfg after reset R10", reg_rdata, 64'h18);
    rst_n = 1; sweep(0, 32);

    cur_req = "R9";
    wr(1, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(11, 64'h1234_5678_9ABC);
    wr(6, 64'hDEAD_BEEF);          // source write ignored
    sweep(0, 12);

    cur_req = "R8";
    reg_addr = 32; reg_we = 1; reg_wdata = 64'h4; br_valid = 1; br_from = 48'h55; br_to = 48'h66;
    tick(); reg_we = 0; br_valid = 0;
    cur_req = "R3";
    reg_addr = 32;
    for (int k = 0; k < 5; k++) begin branch(1); tick(); end
    cur_req = "R7"; check("vb R7", reg_rdata[5], 1);
    cur_req = "R1"; sweep(0, 12);

    cur_req = "R6";
    wr(32, 64'h0300_0000);          // stop, clear, select counter 3
    branch(2);
    ovf_vec = 8'h04; tick(); ovf_vec = 0; tick();
    reg_addr = 32; reg_we = 1; reg_wdata = 64'h0300_0000; ovf_vec = 8'h08; tick(); reg_we = 0; ovf_vec = 0;
    ovf_vec = 8'h08; tick(); ovf_vec = 0;
    cur_req = "R9";
    reg_addr = 1; reg_we = 1; reg_wdata = 64'hAAAA; branch(1); reg_we = 0;
    reg_addr = 32;
    cur_req = "R4"; branch(20);
    cur_req = "R1"; sweep(0, 32);

    cur_req = "R6";
    ovf_vec = 8'h08; tick(); ovf_vec = 0; tick();
    cur_req = "R5";
    wr(32, 64'h0300_0020); tick();
    check("irq kept R5", 64'(irq), 64'd1);
    wr(32, 64'h0); tick();
    check("irq cleared R5", 64'(irq), 64'd0);

    cur_req = "R4";
    wr(32, 64'h000E_0004);
    branch(3); tick();
    cur_req = "R1"; sweep(26, 40);
    cur_req = "R2"; wr(32, 64'hFFFF_FFFF_FFFF_FFE3); reg_addr = 32; tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule